// File: doc/BRIEF.md
# Zero-Crossing Interval Commutation Timer

This block times the gap between successive back-EMF zero-crossing strobes of a brushless motor and schedules the next commutation. A zero-crossing strobe does several things at once. It stores the running interval count as the newest interval. It moves the older newest interval into a history register. It restarts the count from zero. It also arms a delay of a weighted fraction of the stored interval. When that delay has run out, the block raises a one-clock commutation strobe.

The interval counter is 8 bits wide and advances on a prescaled tick. The tick period is 2^s clocks, where s is a power-of-two exponent. The exponent is the sum of a configured base and an automatic boost, capped at 7. When an interval runs so long that the counter pins at 255, the boost goes up by one on that zero crossing. Every later interval is then timed at half the previous rate. The delay is counted on the same tick stream.

Top module: `zc_commute_timer`

## Requirements
- R1: While reset is high and right after it is released, both interval outputs, the weight output, the commutation strobe, the overflow flag and the late-event flag are 0, and the automatic boost is 0, so the tick exponent output equals the configured base.
- R2: The tick period is 2^s clocks, where s is the tick exponent output. The tick counter restarts at each zero-crossing edge. If N clocks separate two zero-crossing edges, the newest-interval output becomes min((N-1) >> s, 255), and the counter restarts from 0.
- R3: On each zero-crossing edge, the history-interval output takes the value the newest-interval output held just before that edge.
- R4: The interval counter stops at 255 and does not wrap. Once the counter holds 255, the overflow flag goes high one clock later and stays high until reset.
- R5: When a zero crossing captures 255, the automatic boost rises by 1, saturating at 7. The tick exponent output is min(base + boost, 7).
- R6: On each zero-crossing edge, the weight input is latched into the weight output register.
- R7: Let C be the captured interval and W the weight latched on the same edge. The delay is T = (W*C) >> 8 ticks. The commutation strobe is high in exactly the clock that starts T*2^s + 1 clocks after that edge, where s is the exponent in force after the edge.
- R8: The commutation strobe is one clock wide and occurs at most once per zero crossing. It never occurs before the first zero crossing after reset.
- R9: A zero crossing that arrives while a delay is still pending drops the old strobe and sets the late-event flag. The flag stays high until reset. The delay restarts from the new capture, and the zero-crossing edge itself produces no strobe.
- R10: The base exponent input sets the tick period with no boost. With base 2, an interval of N clocks captures (N-1) >> 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_evt | input | 1 | Zero-crossing strobe, one clock per event |
| weight_in | input | 8 | Delay weight, in units of 1/256 of an interval |
| presc_cfg | input | 3 | Base tick exponent |
| interval_cur | output | 8 | Newest captured interval |
| interval_prv | output | 8 | Interval captured one zero crossing earlier |
| weight_q | output | 8 | Weight latched at the last zero crossing |
| tick_shift | output | 3 | Tick exponent in force |
| comm_evt | output | 1 | Commutation strobe |
| ovf_flag | output | 1 | Sticky interval-overflow flag |
| late_err | output | 1 | Sticky flag for a zero crossing that arrived during a pending delay |

## Verification
The bench sweeps interval lengths from one clock upward and predicts each captured value and each strobe position by arithmetic. An off-by-one in the tick phase or in the delay compare would show up as an interval or strobe that is one tick early or late. It uses weights of 0 and 255: a weight of 0 must fire one clock after the edge, and a weight of 255 must give nearly the full interval. It drives intervals long enough to pin the counter, then checks that the exponent boost steps up and saturates and that later captures use the slower tick. A design that wrapped the counter or left the rate unchanged would capture small wrong values there. Finally, it sends a zero crossing into a pending delay. A design that let the stale strobe through, or did not restart the delay, would strobe at the wrong clock or miss the late-event flag.

// File: rtl/zct_pkg.sv
package zct_pkg;

    localparam int IVL_W   = 8;
    localparam int WGT_W   = 8;
    localparam int SHIFT_W = 3;

    typedef enum logic {
        DLY_IDLE = 1'b0,
        DLY_RUN  = 1'b1
    } dly_state_e;

    // Adds base and boost, clamping at the largest exponent.
    function automatic logic [SHIFT_W-1:0] clamp_shift(
        input logic [SHIFT_W-1:0] base,
        input logic [SHIFT_W-1:0] boost
    );
        logic [SHIFT_W:0] sum;
        sum = {1'b0, base} + {1'b0, boost};
        if (sum[SHIFT_W])
            return {SHIFT_W{1'b1}};
        return sum[SHIFT_W-1:0];
    endfunction

endpackage

// File: rtl/zct_prescaler.sv
module zct_prescaler
    import zct_pkg::*;
#(
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc,
    input  logic          sat_at_z,
    input  logic [SW-1:0] base,
    output logic          tick,
    output logic [SW-1:0] shift
);
    localparam int MAX_SH = (1 << SW) - 1;
    localparam int PRE_W  = (MAX_SH > 0) ? MAX_SH : 1;

    logic [SW-1:0]  boost_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;

    always_comb begin
        shift  = clamp_shift(base, boost_q);
        one_sh = {{PRE_W{1'b0}}, 1'b1} << shift;
        mask   = one_sh[PRE_W-1:0] - PRE_W'(1);
        tick   = ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            boost_q <= '0;
            pre_q   <= '0;
        end else if (zc) begin
            pre_q <= '0;
            if (sat_at_z && boost_q != SW'(MAX_SH))
                boost_q <= boost_q + SW'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_BOOST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> boost_q >= $past(boost_q)); // R5

    AST_BOOST_STEP: assert property (@(posedge clk) disable iff (rst)
        (zc && sat_at_z && boost_q != SW'(MAX_SH)) |=> boost_q == $past(boost_q) + SW'(1)); // R5

endmodule

// File: rtl/zct_interval.sv
module zct_interval
    import zct_pkg::*;
#(
    parameter int IW = IVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc,
    input  logic          tick,
    output logic [IW-1:0] live,
    output logic          full,
    output logic [IW-1:0] cur,
    output logic [IW-1:0] prv,
    output logic          ovf
);
    localparam logic [IW-1:0] CNT_MAX = {IW{1'b1}};

    typedef struct packed {
        logic [IW-1:0] cur;
        logic [IW-1:0] prv;
    } ivl_pair_t;

    ivl_pair_t     pair_q;
    logic [IW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (cnt_q == CNT_MAX)
                ovf_q <= 1'b1;
            if (zc) begin
                pair_q.cur <= cnt_q;
                pair_q.prv <= pair_q.cur;
                cnt_q      <= '0;
            end else if (tick && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + IW'(1);
            end
        end
    end

    assign live = cnt_q;
    assign full = (cnt_q == CNT_MAX);
    assign cur  = pair_q.cur;
    assign prv  = pair_q.prv;
    assign ovf  = ovf_q;

    AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (rst)
        zc |=> pair_q.prv == $past(pair_q.cur)); // R3

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        zc |=> cnt_q == '0); // R2

    AST_COUNT_PINNED: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !zc) |=> cnt_q == CNT_MAX); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R4

endmodule

// File: rtl/zct_delay.sv
module zct_delay
    import zct_pkg::*;
#(
    parameter int IW = IVL_W,
    parameter int WW = WGT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc,
    input  logic          tick,
    input  logic [IW-1:0] ivl,
    input  logic [WW-1:0] weight_in,
    output logic [WW-1:0] weight_q,
    output logic          comm,
    output logic          err
);
    localparam int PW = IW + WW;

    dly_state_e    state_q;
    logic [IW-1:0] dly_q;
    logic [IW-1:0] tgt_q;
    logic [WW-1:0] wgt_q;
    logic          comm_q;
    logic          err_q;
    logic [PW-1:0] prod;

    assign prod = {{WW{1'b0}}, ivl} * {{IW{1'b0}}, weight_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DLY_IDLE;
            dly_q   <= '0;
            tgt_q   <= '0;
            wgt_q   <= '0;
            comm_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            comm_q <= 1'b0;
            if (zc) begin
                if (state_q == DLY_RUN)
                    err_q <= 1'b1;
                wgt_q   <= weight_in;
                tgt_q   <= prod[PW-1:WW];
                dly_q   <= '0;
                state_q <= DLY_RUN;
            end else if (state_q == DLY_RUN) begin
                if (dly_q == tgt_q) begin
                    comm_q  <= 1'b1;
                    state_q <= DLY_IDLE;
                end else if (tick) begin
                    dly_q <= dly_q + IW'(1);
                end
            end
        end
    end

    assign weight_q = wgt_q;
    assign comm     = comm_q;
    assign err      = err_q;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        comm_q |=> !comm_q); // R8

    AST_STROBE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(comm_q) |-> $past(state_q == DLY_RUN)); // R7

    AST_ZC_REARMS: assert property (@(posedge clk) disable iff (rst)
        zc |=> (state_q == DLY_RUN && !comm_q)); // R9

    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R9

endmodule

// File: rtl/zc_commute_timer.sv
module zc_commute_timer
    import zct_pkg::*;
#(
    parameter int IW = IVL_W,
    parameter int WW = WGT_W,
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc_evt,
    input  logic [WW-1:0] weight_in,
    input  logic [SW-1:0] presc_cfg,
    output logic [IW-1:0] interval_cur,
    output logic [IW-1:0] interval_prv,
    output logic [WW-1:0] weight_q,
    output logic [SW-1:0] tick_shift,
    output logic          comm_evt,
    output logic          ovf_flag,
    output logic          late_err
);
    logic          tick;
    logic          cnt_full;
    logic [IW-1:0] cnt_live;

    zct_prescaler #(.SW(SW)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .zc       (zc_evt),
        .sat_at_z (cnt_full),
        .base     (presc_cfg),
        .tick     (tick),
        .shift    (tick_shift)
    );

    zct_interval #(.IW(IW)) u_ivl (
        .clk  (clk),
        .rst  (rst),
        .zc   (zc_evt),
        .tick (tick),
        .live (cnt_live),
        .full (cnt_full),
        .cur  (interval_cur),
        .prv  (interval_prv),
        .ovf  (ovf_flag)
    );

    zct_delay #(.IW(IW), .WW(WW)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .zc        (zc_evt),
        .tick      (tick),
        .ivl       (cnt_live),
        .weight_in (weight_in),
        .weight_q  (weight_q),
        .comm      (comm_evt),
        .err       (late_err)
    );

    AST_NO_STROBE_ON_ZC: assert property (@(posedge clk) disable iff (rst)
        zc_evt |=> !comm_evt); // R9

endmodule

// File: tb/zc_commute_timer_tb_top.sv
`timescale 1ns/1ps
module zc_commute_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_evt = 1'b0;
    logic [7:0] weight_in = 8'd0;
    logic [2:0] presc_cfg = 3'd0;
    logic [7:0] interval_cur, interval_prv, weight_q;
    logic [2:0] tick_shift;
    logic       comm_evt, ovf_flag, late_err;

    zc_commute_timer dut_i (
        .clk          (clk),
        .rst          (rst),
        .zc_evt       (zc_evt),
        .weight_in    (weight_in),
        .presc_cfg    (presc_cfg),
        .interval_cur (interval_cur),
        .interval_prv (interval_prv),
        .weight_q     (weight_q),
        .tick_shift   (tick_shift),
        .comm_evt     (comm_evt),
        .ovf_flag     (ovf_flag),
        .late_err     (late_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int cfg_m, boost_m, e_m, cur_m, prv_m, wq_m, ovf_m, err_m, armed, exp_d;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(int cfg);
        rst = 1'b1;
        zc_evt = 1'b0;
        presc_cfg = 3'(cfg);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_m = cfg; boost_m = 0; e_m = cfg;
        cur_m = 0; prv_m = 0; wq_m = 0; ovf_m = 0; err_m = 0; armed = 0; exp_d = 0;
        // R1: outputs still at reset values right after release
        chk(interval_cur == 0, "R1 interval_cur", int'(interval_cur), 0);
        chk(interval_prv == 0, "R1 interval_prv", int'(interval_prv), 0);
        chk(weight_q == 0, "R1 weight_q", int'(weight_q), 0);
        chk(comm_evt == 0 && ovf_flag == 0 && late_err == 0, "R1 flags",
            int'({comm_evt, ovf_flag, late_err}), 0);
        chk(int'(tick_shift) == cfg, "R1 tick_shift", int'(tick_shift), cfg);
    endtask

    // Observe gap clocks with no zero crossing; check strobe count and position.
    task automatic watch(int gap);
        int seen = 0;
        int at = 0;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (comm_evt) begin
                seen++;
                at = i;
            end
        end
        if (!armed) begin
            chk(seen == 0, "R8 no strobe before first zero crossing", seen, 0);
        end else if (exp_d <= gap) begin
            chk(seen == 1, "R8 one strobe per zero crossing", seen, 1);
            chk(at == exp_d, "R7 strobe position", at, exp_d);
        end else begin
            chk(seen == 0, "R9 pending strobe not yet due", seen, 0);
        end
    endtask

    task automatic z_event(int gap, int w);
        int cap;
        int t;
        watch(gap);
        if (armed && exp_d > gap)
            err_m = 1;
        zc_evt = 1'b1;
        weight_in = 8'(w);
        @(negedge clk);
        zc_evt = 1'b0;
        cap = gap >> e_m;
        if (cap > 255) cap = 255;
        prv_m = cur_m;
        cur_m = cap;
        wq_m = w;
        if (cap == 255) begin
            ovf_m = 1;
            if (boost_m < 7) boost_m++;
        end
        e_m = (cfg_m + boost_m > 7) ? 7 : cfg_m + boost_m;
        t = (w * cap) >> 8;
        exp_d = (t << e_m) + 1;
        armed = 1;
        chk(int'(interval_cur) == cur_m, "R2 interval_cur", int'(interval_cur), cur_m);
        chk(int'(interval_prv) == prv_m, "R3 interval_prv", int'(interval_prv), prv_m);
        chk(int'(ovf_flag) == ovf_m, "R4 ovf_flag", int'(ovf_flag), ovf_m);
        chk(int'(tick_shift) == e_m, "R5 tick_shift", int'(tick_shift), e_m);
        chk(int'(weight_q) == wq_m, "R6 weight_q", int'(weight_q), wq_m);
        chk(int'(late_err) == err_m, "R9 late_err", int'(late_err), err_m);
        chk(comm_evt == 1'b0, "R9 no strobe on zero-crossing edge", int'(comm_evt), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        // R2 R3 R7: interval sweep with half weight
        for (int g = 1; g <= 40; g++)
            z_event(g, 128);
        // R7: extreme and mixed weights
        z_event(60, 0);
        z_event(50, 255);
        z_event(70, 1);
        z_event(90, 77);
        z_event(120, 255);
        // R9: zero crossing during pending delay, then recovery
        z_event(200, 255);
        z_event(20, 200);
        z_event(30, 100);
        // R4 R5: overflow raises the exponent twice
        z_event(300, 128);
        z_event(600, 128);
        z_event(100, 255);
        z_event(410, 64);
        watch(900);

        // R10: base exponent 2, then overflow boosts up to the cap
        do_reset(2);
        for (int g = 4; g <= 64; g += 5)
            z_event(g, 128);
        z_event(400, 200);
        do_reset(5);
        z_event(100, 128);
        z_event(8200, 128);
        z_event(16400, 128);
        z_event(32700, 128);
        z_event(3000, 255);
        watch(3100);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule